// File: doc/BRIEF.md
# Flash Region Protection Controller

This block guards a small word-addressed flash array. Every request is one of four kinds: data read, instruction fetch, program or block erase. The block checks the request against the protection entry that covers the target address. A request that passes is carried out. A request that fails gets no access: it returns an error response with zero data, sets a sticky violation flag and pulses an interrupt. The array is built from erase blocks of `BLOCK_BYTES` each (1 KB by default), and `NUM_BLOCKS` sets the depth. The default of 8 blocks is a reduced size for simulation; the full device size is 128 blocks. Two neighbouring erase blocks form one protection unit, so protection is twice as coarse as erase. Each unit holds a read-enable bit and a program-enable bit.

Only one request is in flight at a time. In `ST_IDLE` the block raises `req_ready` and decides on the request in the cycle it is accepted. From there it goes to one of four states:
- `ST_READ_RESP` when a read or fetch is allowed.
- `ST_REFUSE` when the request is denied.
- `ST_PROGRAM` when a program is allowed. The block stays there for `PROG_CYCLES` cycles.
- `ST_ERASE` when an erase is allowed. The block stays there for `max(ERASE_CYCLES, BLOCK_WORDS)` cycles and writes all ones to one word of the block per cycle.

`ST_PROGRAM` and `ST_ERASE` both move to `ST_DONE` when their count expires. `ST_READ_RESP`, `ST_REFUSE` and `ST_DONE` each last one cycle, drive `rsp_valid`, and return to `ST_IDLE`. Software reaches the protection bits and the flag through a small register port. Protection bits can only be cleared, and only reset sets them again.

Top module: `flash_prot_ctrl`

## Requirements
- R1: A data read (`req_op`=0) of a unit whose read-enable bit (entry bit 0) is 1 returns the stored word with `rsp_valid` high and `rsp_error` low in the cycle after acceptance.
- R2: An instruction fetch (`req_op`=1) is allowed in every unit whatever its entry bits, and returns the stored word in the cycle after acceptance.
- R3: A data read of a unit with read-enable 0 is refused. The response carries `rsp_error`=1 and `rsp_rdata`=0, `irq` is high for that one response cycle, and the violation flag is set. An entry of 00 (execute-only) therefore serves fetches only.
- R4: An allowed program (`req_op`=2) stores the bitwise AND of the write data and the old word, so bits can only go from 1 to 0.
- R5: A program to a unit whose program-enable bit (entry bit 1) is 0 is refused with `rsp_error`, and the word is left unchanged.
- R6: An allowed erase (`req_op`=3) sets every word of the addressed erase block to all ones and leaves the other block of the same unit unchanged.
- R7: An erase to a unit with program-enable 0 is refused with `rsp_error`, and the block is left unchanged.
- R8: Both erase blocks of a unit (address bits [ADDR_W-1:OFF_W+1] select the unit) obey one entry, and a change to one unit's entry has no effect on any other unit.
- R9: A register write to a protection entry (`reg_addr` top bit 0, lower bits = unit) ANDs `reg_wdata` into the entry. Bits therefore never go from 0 to 1 until the next reset.
- R10: The violation flag (status at `reg_addr` top bit 1, bit 0) stays set until a write with bit 0 = 1 to the status address. A write with bit 0 = 0 leaves it set.
- R11: During a program `busy` is high for exactly `PROG_CYCLES` cycles, and during an erase for exactly `max(ERASE_CYCLES, BLOCK_WORDS)` cycles. `req_ready` is low for the whole time.
- R12: After reset every entry reads 11, the flag reads 0, `busy`, `rsp_valid` and `irq` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_op | input | 2 | 0 data read, 1 instruction fetch, 2 program, 3 erase |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Data for a program |
| req_ready | output | 1 | Block idle and able to accept |
| busy | output | 1 | Program or erase in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_error | output | 1 | Request was refused |
| rsp_rdata | output | WORD_W | Read or fetch data; zero when refused |
| irq | output | 1 | One-cycle pulse on a refusal |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | UNIT_W+1 | Top bit 1 selects status; otherwise the lower bits pick a unit |
| reg_wdata | input | 2 | Entry: bit0 read-enable, bit1 program-enable; status: bit0 clears the flag |
| reg_rdata | output | 2 | Selected entry, or the flag in bit 0 |

## Verification
The assertions assume that `req_valid` is raised only while `req_ready` is high. They also assume the address lies inside the array and that no protection entry is changed while a program or erase is running. The bench meets all three conditions. It issues each request from a task that waits for the previous response, draws addresses only within the array depth, and writes protection registers only between requests. Reads of never-erased words are avoided by erasing the whole array first, so every read compares against a defined model value.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_FETCH = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_RESP = 3'd1,
        ST_REFUSE    = 3'd2,
        ST_PROGRAM   = 3'd3,
        ST_ERASE     = 3'd4,
        ST_DONE      = 3'd5
    } state_e;

endpackage

// File: rtl/flash_prot_check.sv
module flash_prot_check
    import flash_prot_pkg::*;
(
    input  logic [1:0] op,
    input  logic       rd_en,
    input  logic       pg_en,
    output logic       allow
);
    always_comb begin
        unique case (op_e'(op))
            OP_READ:  allow = rd_en;
            OP_FETCH: allow = 1'b1;
            OP_PROG:  allow = pg_en;
            OP_ERASE: allow = pg_en;
            default:  allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs #(
    parameter int NUM_UNITS = 4,
    parameter int UNIT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [UNIT_W:0]   reg_addr,
    input  logic [1:0]        reg_wdata,
    output logic [1:0]        reg_rdata,
    input  logic              viol_set,
    input  logic [UNIT_W-1:0] lookup_unit,
    output logic              unit_rd_en,
    output logic              unit_pg_en,
    output logic              flag
);
    logic [NUM_UNITS-1:0] rd_vec;
    logic [NUM_UNITS-1:0] pg_vec;
    logic                 flag_q;
    logic                 status_sel;
    logic                 clr_hit;

    assign status_sel = reg_addr[UNIT_W];
    assign clr_hit    = reg_wr && status_sel && reg_wdata[0];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic rd_q;
        logic pg_q;
        logic hit;
        assign hit = reg_wr && !status_sel && (reg_addr[UNIT_W-1:0] == UNIT_W'(u));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= 1'b1;
                pg_q <= 1'b1;
            end else if (hit) begin
                rd_q <= rd_q & reg_wdata[0];
                pg_q <= pg_q & reg_wdata[1];
            end
        end
        assign rd_vec[u] = rd_q;
        assign pg_vec[u] = pg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (viol_set) flag_q <= 1'b1;
        else if (clr_hit)  flag_q <= 1'b0;
    end

    always_comb begin
        if (status_sel) reg_rdata = {1'b0, flag_q};
        else            reg_rdata = {pg_vec[reg_addr[UNIT_W-1:0]], rd_vec[reg_addr[UNIT_W-1:0]]};
    end

    assign unit_rd_en = rd_vec[lookup_unit];
    assign unit_pg_en = pg_vec[lookup_unit];
    assign flag       = flag_q;

    // R9: protection bits never rise while out of reset
    assert_bits_never_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_vec & ~$past(rd_vec)) == '0) && ((pg_vec & ~$past(pg_vec)) == '0));

    // R10: flag stays set unless cleared by a write of one
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) && !$past(clr_hit)) |-> flag_q);
endmodule

// File: rtl/flash_prot_array.sv
module flash_prot_array #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[addr];
        if (wr_en) begin
            if (wr_fill) mem[addr] <= '1;
            else         mem[addr] <= mem[addr] & wdata;
        end
    end

    // R11: a read never overlaps a program or erase write
    assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
    import flash_prot_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int BLOCK_BYTES  = 1024,
    parameter int NUM_BLOCKS   = 8,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 256,
    localparam int WORD_BYTES  = WORD_W / 8,
    localparam int BLOCK_WORDS = BLOCK_BYTES / WORD_BYTES,
    localparam int DEPTH       = NUM_BLOCKS * BLOCK_WORDS,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int NUM_UNITS   = NUM_BLOCKS / 2,
    localparam int UNIT_W      = $clog2(NUM_UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              irq,
    input  logic              reg_wr,
    input  logic [UNIT_W:0]   reg_addr,
    input  logic [1:0]        reg_wdata,
    output logic [1:0]        reg_rdata
);
    localparam int OFF_W     = $clog2(BLOCK_WORDS);
    localparam int ERASE_LEN = (ERASE_CYCLES > BLOCK_WORDS) ? ERASE_CYCLES : BLOCK_WORDS;
    localparam int CNT_W     = $clog2(ERASE_LEN + PROG_CYCLES + 1);

    state_e             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic               unit_rd_en, unit_pg_en, flag;
    logic               allow;
    logic               accept, viol_set;
    logic               arr_rd, arr_wr, arr_fill;
    logic [ADDR_W-1:0]  arr_addr;
    logic [WORD_W-1:0]  arr_rdata;
    logic               prog_last, erase_last, erase_write;
    logic [UNIT_W-1:0]  lookup_unit;
    logic [CNT_W:0]     busy_len_q;

    assign lookup_unit = req_addr[ADDR_W-1 -: UNIT_W];
    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign prog_last   = (cnt_q == CNT_W'(PROG_CYCLES - 1));
    assign erase_last  = (cnt_q == CNT_W'(ERASE_LEN - 1));
    assign erase_write = (cnt_q < CNT_W'(BLOCK_WORDS));

    flash_prot_regs #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .viol_set(viol_set), .lookup_unit(lookup_unit),
        .unit_rd_en(unit_rd_en), .unit_pg_en(unit_pg_en), .flag(flag)
    );

    flash_prot_check u_check (
        .op(req_op), .rd_en(unit_rd_en), .pg_en(unit_pg_en), .allow(allow)
    );

    flash_prot_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_en(arr_rd), .wr_en(arr_wr), .wr_fill(arr_fill),
        .addr(arr_addr), .wdata(wdata_q), .rdata(arr_rdata)
    );

    // state register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PROGRAM || state_q == ST_ERASE) cnt_q <= cnt_q + 1'b1;
            else                                              cnt_q <= '0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!allow) state_d = ST_REFUSE;
                    else begin
                        unique case (op_e'(req_op))
                            OP_READ, OP_FETCH: state_d = ST_READ_RESP;
                            OP_PROG:           state_d = ST_PROGRAM;
                            OP_ERASE:          state_d = ST_ERASE;
                            default:           state_d = ST_REFUSE;
                        endcase
                    end
                end
            end
            ST_PROGRAM: if (prog_last)  state_d = ST_DONE;
            ST_ERASE:   if (erase_last) state_d = ST_DONE;
            ST_READ_RESP, ST_REFUSE, ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b0;
        rsp_valid = 1'b0;
        rsp_error = 1'b0;
        rsp_rdata = '0;
        irq       = 1'b0;
        viol_set  = 1'b0;
        arr_rd    = 1'b0;
        arr_wr    = 1'b0;
        arr_fill  = 1'b0;
        arr_addr  = addr_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                arr_addr  = req_addr;
                viol_set  = req_valid && !allow;
                arr_rd    = req_valid && allow &&
                            (op_e'(req_op) == OP_READ || op_e'(req_op) == OP_FETCH);
            end
            ST_READ_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = arr_rdata;
            end
            ST_REFUSE: begin
                rsp_valid = 1'b1;
                rsp_error = 1'b1;
                irq       = 1'b1;
            end
            ST_PROGRAM: begin
                busy   = 1'b1;
                arr_wr = prog_last;
            end
            ST_ERASE: begin
                busy     = 1'b1;
                arr_fill = 1'b1;
                arr_wr   = erase_write;
                arr_addr = {addr_q[ADDR_W-1:OFF_W], cnt_q[OFF_W-1:0]};
            end
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // checker-only run length of busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 1'b1;
        else           busy_len_q <= '0;
    end

    // R11: busy never exceeds the longest operation
    assert_busy_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len_q <= (CNT_W+1)'(ERASE_LEN));

    // R3: a denied data read sets the flag and pulses irq next cycle
    assert_read_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_READ && !unit_rd_en) |=> (flag && irq && rsp_error));

    // R2: fetch is never refused
    assert_fetch_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_FETCH) |=> (rsp_valid && !rsp_error));

    // R5: program to a locked unit never enters the program state
    assert_prog_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_PROG && !unit_pg_en) |=> (state_q == ST_REFUSE));

    // R7: erase to a locked unit never enters the erase state
    assert_erase_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_e'(req_op) == OP_ERASE && !unit_pg_en) |=> (state_q == ST_REFUSE));

    // R3: irq is a single-cycle pulse
    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/sim_flash_prot_ctrl.sv
module sim_flash_prot_ctrl;
    localparam int BW    = 256;
    localparam int DEPTH = 2048;
    localparam int PC    = 4;
    localparam int EC    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [10:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, busy, rsp_valid, rsp_error, irq;
    logic [31:0] rsp_rdata;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_wdata = '0;
    logic [1:0]  reg_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] mm [DEPTH];
    logic [1:0]  ent [4];

    always #2.5 clk = ~clk;

    flash_prot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
        .rsp_rdata(rsp_rdata), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit allowed(input int op, input logic [1:0] e);
        case (op)
            0: return e[0];
            1: return 1'b1;
            default: return e[1];
        endcase
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [1:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic issue(input int op, input logic [10:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic err, output logic irq_s,
                         output int bc, output int stall_bad);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        bc = 0; stall_bad = 0;
        for (int g = 0; g < 2000 && !rsp_valid; g++) begin
            if (busy) begin bc++; if (req_ready) stall_bad++; end
            @(negedge clk);
        end
        rd = rsp_rdata; err = rsp_error; irq_s = irq;
    endtask

    task automatic apply(input int op, input logic [10:0] a, input logic [31:0] d);
        logic [31:0] rd; logic err, irq_s; int bc, sb; logic [1:0] st;
        bit ok = allowed(op, ent[a[10:9]]);
        issue(op, a, d, rd, err, irq_s, bc, sb);
        case (op)
            0: if (ok) chk(!err && rd == mm[a], "R1 read data", rd, mm[a]);
               else    chk(err && rd == 0 && irq_s, "R3 refused read", rd, 32'h0);
            1: chk(!err && rd == mm[a], "R2 fetch data", rd, mm[a]);
            2: if (ok) begin
                   chk(!err && bc == PC && sb == 0, "R11 program busy", 32'(bc), 32'(PC));
                   mm[a] = mm[a] & d;
               end else chk(err, "R5 refused program", 32'(err), 32'h1);
            default: if (ok) begin
                   chk(!err && bc == EC && sb == 0, "R11 erase busy", 32'(bc), 32'(EC));
                   for (int i = 0; i < BW; i++) mm[{a[10:8], 8'(i)}] = '1;
               end else chk(err, "R7 refused erase", 32'(err), 32'h1);
        endcase
        if (!ok) begin
            reg_read(3'b100, st);
            chk(st == 2'b01, "R10 flag set", 32'(st), 32'h1);
            reg_write(3'b100, 2'b01);
            reg_read(3'b100, st);
            chk(st == 2'b00, "R10 flag cleared", 32'(st), 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic err, irq_s; int bc, sb; logic [1:0] st;
        void'($urandom(32'd20240611));
        for (int u = 0; u < 4; u++) ent[u] = 2'b11;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && req_ready && !rsp_valid && !irq, "R12 idle outputs", {busy, req_ready, rsp_valid, irq}, 32'h4);
        rst_n = 1'b1;
        for (int u = 0; u < 4; u++) begin
            reg_read(3'(u), st);
            chk(st == 2'b11, "R12 entry reset", 32'(st), 32'h3);
        end
        reg_read(3'b100, st);
        chk(st == 2'b00, "R12 flag reset", 32'(st), 32'h0);

        // erase whole array (R6)
        for (int b = 0; b < 8; b++) apply(3, 11'(b * BW), '0);
        apply(0, 11'd0, '0);
        apply(0, 11'd2047, '0);

        // program AND behaviour (R4)
        apply(2, 11'd5, 32'hF0F0_1234);
        apply(0, 11'd5, '0);
        apply(2, 11'd5, 32'h0FFF_FFFF);
        apply(0, 11'd5, '0);
        apply(2, 11'd5, 32'hFFFF_FFFF);
        chk(mm[5] == 32'h00F0_1234, "R4 model AND", mm[5], 32'h00F0_1234);
        apply(0, 11'd5, '0);

        // erase of one block leaves its partner (R6)
        apply(2, 11'd10, 32'h1234_5678);
        apply(2, 11'd300, 32'hAAAA_0000);
        apply(3, 11'd256, '0);
        apply(0, 11'd10, '0);
        apply(0, 11'd300, '0);
        chk(mm[10] == 32'h1234_5678 && mm[300] == 32'hFFFF_FFFF, "R6 partner kept", mm[10], 32'h1234_5678);

        // unit1 read-only: both blocks locked, neighbours open (R5 R7 R8)
        apply(2, 11'd600, 32'h0);
        apply(2, 11'd900, 32'h0000_FFFF);
        reg_write(3'd1, 2'b01); ent[1] = 2'b01;
        apply(2, 11'd600, 32'h0);
        apply(2, 11'd900, 32'h0);
        apply(3, 11'd512, '0);
        apply(3, 11'd768, '0);
        apply(0, 11'd600, '0);
        apply(0, 11'd900, '0);
        apply(2, 11'd1100, 32'h5555_5555);
        apply(0, 11'd1100, '0);
        reg_read(3'd0, st);
        chk(st == 2'b11, "R8 other unit untouched", 32'(st), 32'h3);

        // unit2 execute-only (R2 R3)
        reg_write(3'd2, 2'b00); ent[2] = 2'b00;
        apply(1, 11'd1100, '0);
        issue(0, 11'd1100, '0, rd, err, irq_s, bc, sb);
        chk(err && rd == 0 && irq_s, "R3 exec-only read", rd, 32'h0);
        reg_write(3'b100, 2'b00);
        reg_read(3'b100, st);
        chk(st == 2'b01, "R10 write zero keeps flag", 32'(st), 32'h1);
        reg_write(3'b100, 2'b01);
        reg_read(3'b100, st);
        chk(st == 2'b00, "R10 write one clears", 32'(st), 32'h0);
        apply(2, 11'd1200, 32'h0);
        apply(3, 11'd1024, '0);

        // bits cannot be re-set (R9)
        reg_write(3'd1, 2'b11);
        reg_read(3'd1, st);
        chk(st == 2'b01, "R9 no re-enable", 32'(st), 32'h1);
        reg_write(3'd2, 2'b11);
        reg_read(3'd2, st);
        chk(st == 2'b00, "R9 no re-enable exec", 32'(st), 32'h0);

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 99));
            int op = (r < 35) ? 0 : (r < 60) ? 1 : (r < 96) ? 2 : 3;
            logic [10:0] a = 11'($urandom_range(0, DEPTH - 1));
            apply(op, a, $urandom());
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule